// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad shared by a group of sixteen thread lanes. On each accepted request every lane can present one word access: an activity bit, a word address, a write enable and write data. The storage is split into sixteen independent single-port banks, and each bank serves one row per clock. The block sorts the lanes by the bank their address selects. When two lanes hit the same bank at different rows, the block does not stall them both. It runs the request as a series of passes, and each pass serves every bank once.

Lanes that name the very same word travel together in one pass. A request whose lanes all fall in distinct banks finishes in a single pass. A strided pattern that folds onto fewer banks costs as many passes as the most crowded bank has distinct rows. The issuer sees a ready/valid pair on the request side. A one-cycle completion strobe marks the cycle in which every lane's read data is valid on the output.

Top module: `bank_scratch`

## Requirements
- R1: The bank index of a word address is its low 4 bits and the row is the bits above them. A word written through any lane is returned by a later read of that address through any lane.
- R2: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both high. `done_o` then goes high on the P-th following rising edge, where P is the pass count, and stays high for exactly one cycle.
- R3: Word stride 1 across the sixteen lanes, any odd stride, and any one-to-one lane-to-bank permutation all take one pass.
- R4: The pass count equals the largest number of distinct rows that active lanes request within one bank. Stride 2 takes 2 passes, stride 8 takes 8 passes and stride 16 takes 16 passes.
- R5: Active lanes that name an identical address are served in the same pass and add no pass (broadcast).
- R6: `req_ready_o` is low from the cycle after acceptance until the `done_o` cycle. A `req_valid_i` asserted while ready is low has no effect on memory.
- R7: `done_o` is a one-cycle pulse, and `req_ready_o` is high in the same cycle.
- R8: When several lanes of one request write the same address, the value from the highest-numbered of those lanes is stored.
- R9: A read returns the word as it stood before any write carried out in the same pass, including a write to the same address by another lane.
- R10: Inactive lanes access nothing and their `rdata_o` slice keeps its previous value. A request with no active lane completes in one pass.
- R11: During reset and for two cycles after its release `req_ready_o` and `done_o` are low. `req_ready_o` then rises with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request vector present |
| req_ready_o | output | 1 | Block can take a request this cycle |
| lane_act_i | input | 16 | Per-lane activity bit, bit n is lane n |
| lane_we_i | input | 16 | Per-lane write enable |
| lane_addr_i | input | 160 | Word addresses, lane n at bits [10n+9:10n] |
| lane_wdata_i | input | 512 | Write data, lane n at bits [32n+31:32n] |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 512 | Read data, lane n at bits [32n+31:32n] |

## Verification
Faults in the pending mask or in the per-bank winner selection show up at the ports within one request. Too few passes leave lane slices stale or wrong when `done_o` fires. Too many passes stretch the stall, and the bench measures that stall edge by edge against the conflict degree of the pattern. A bad bank or row split corrupts the stored image, and the readback sweep exposes it on the first read of an affected word. A wrong write-priority or read-before-write order shows up in the data returned by the very next read of the contested word.

// File: rtl/bank_scratch_pkg.sv
package bank_scratch_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/bank_scratch_pick.sv
// Per-bank winner selection for one pass, plus the set of lanes it serves.
module bank_scratch_pick #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic [LANES-1:0]             pend_i,
  input  logic [LANES-1:0][ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]             we_i,
  input  logic [LANES-1:0][DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]             served_o,
  output logic [BANKS-1:0][ROW_W-1:0]  bank_row_o,
  output logic [BANKS-1:0]             bank_we_o,
  output logic [BANKS-1:0][DATA_W-1:0] bank_wdata_o
);

  logic [BANKS-1:0] bank_hit;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] BIDX = BANK_W'(b);
    logic              hit;
    logic [ROW_W-1:0]  hrow;
    logic              hwe;
    logic [DATA_W-1:0] hwd;

    always_comb begin
      hit  = 1'b0;
      hrow = '0;
      hwe  = 1'b0;
      hwd  = '0;
      // lowest pending lane owns the bank for this pass
      for (int l = 0; l < LANES; l++) begin
        if (!hit && pend_i[l] && (addr_i[l][BANK_W-1:0] == BIDX)) begin
          hit  = 1'b1;
          hrow = addr_i[l][ADDR_W-1:BANK_W];
        end
      end
      // ascending scan: the highest writer to the owned word wins
      for (int l = 0; l < LANES; l++) begin
        if (hit && pend_i[l] && we_i[l] && (addr_i[l] == {hrow, BIDX})) begin
          hwe = 1'b1;
          hwd = wdata_i[l];
        end
      end
    end

    assign bank_hit[b]     = hit;
    assign bank_row_o[b]   = hrow;
    assign bank_we_o[b]    = hwe;
    assign bank_wdata_o[b] = hwd;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BANK_W-1:0] bsel;
    assign bsel        = addr_i[l][BANK_W-1:0];
    assign served_o[l] = pend_i[l] && bank_hit[bsel]
                         && (bank_row_o[bsel] == addr_i[l][ADDR_W-1:BANK_W]);
  end

endmodule

// File: rtl/bank_scratch_bank.sv
// One single-port bank: combinational read of the pre-edge contents.
module bank_scratch_bank #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 32,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[row_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[row_i];

endmodule

// File: rtl/bank_scratch_route.sv
// Read crossbar: each lane picks the output of the bank its address selects.
module bank_scratch_route #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic [LANES-1:0][BANK_W-1:0] sel_i,
  input  logic [BANKS-1:0][DATA_W-1:0] bank_rdata_i,
  output logic [LANES-1:0][DATA_W-1:0] lane_rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_xbar
    assign lane_rdata_o[l] = bank_rdata_i[sel_i[l]];
  end

endmodule

// File: rtl/bank_scratch.sv
module bank_scratch
  import bank_scratch_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES-1:0]        lane_act_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*ADDR_W-1:0] lane_addr_i,
  input  logic [LANES*DATA_W-1:0] lane_wdata_i,
  output logic                    done_o,
  output logic [LANES*DATA_W-1:0] rdata_o
);

  // reset: asynchronous assertion, release through two flops
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  run_state_e                   state_q, state_d;
  logic [LANES-1:0]             pend_q, pend_d;
  logic                         done_q, done_d;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]             we_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q;
  logic [LANES-1:0][DATA_W-1:0] rdata_q;

  logic                         accept, running, last_pass;
  logic [LANES-1:0]             served;
  logic [BANKS-1:0][ROW_W-1:0]  bank_row;
  logic [BANKS-1:0]             bank_we;
  logic [BANKS-1:0][DATA_W-1:0] bank_wdata;
  logic [BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [LANES-1:0][BANK_W-1:0] lane_sel;
  logic [LANES-1:0][DATA_W-1:0] lane_rdata;

  assign running     = (state_q == ST_RUN);
  assign req_ready_o = (state_q == ST_IDLE) && rst_int_n;
  assign accept      = req_valid_i && req_ready_o;
  assign last_pass   = running && ((pend_q & ~served) == '0);

  // next-state process
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    done_d  = last_pass;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RUN;
          pend_d  = lane_act_i;
        end
      end
      ST_RUN: begin
        pend_d = pend_q & ~served;
        if (last_pass) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= lane_addr_i;
      we_q    <= lane_we_i;
      wdata_q <= lane_wdata_i;
    end
  end

  bank_scratch_pick #(
    .LANES (LANES),
    .BANKS (BANKS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) pick_i (
    .pend_i      (pend_q),
    .addr_i      (addr_q),
    .we_i        (we_q),
    .wdata_i     (wdata_q),
    .served_o    (served),
    .bank_row_o  (bank_row),
    .bank_we_o   (bank_we),
    .bank_wdata_o(bank_wdata)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_mem
    bank_scratch_bank #(
      .ROW_W (ROW_W),
      .DATA_W(DATA_W)
    ) bank_i (
      .clk    (clk),
      .we_i   (bank_we[b] && running),
      .row_i  (bank_row[b]),
      .wdata_i(bank_wdata[b]),
      .rdata_o(bank_rdata[b])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_sel
    assign lane_sel[l] = addr_q[l][BANK_W-1:0];
  end

  bank_scratch_route #(
    .LANES (LANES),
    .BANKS (BANKS),
    .DATA_W(DATA_W)
  ) route_i (
    .sel_i       (lane_sel),
    .bank_rdata_i(bank_rdata),
    .lane_rdata_o(lane_rdata)
  );

  // per-lane result registers, each enabled when its lane is served
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        rdata_q[l] <= '0;
      end else if (running && served[l]) begin
        rdata_q[l] <= lane_rdata[l];
      end
    end
  end

  assign done_o  = done_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/bank_scratch_chk.sv
module bank_scratch_chk #(
  parameter int LANES = 16,
  localparam int CNT_W = $clog2(LANES + 4) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             done_o,
  input logic [LANES-1:0] pend_q
);

  logic [CNT_W-1:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stall_cnt <= '0;
    else if (req_ready_o) stall_cnt <= '0;
    else                  stall_cnt <= stall_cnt + 1'b1;
  end

  p_accept_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_done_after_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !$past(req_ready_o));

  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (pend_q == '0));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready_o);

  p_pend_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready_o && !$past(req_ready_o)) |-> ((pend_q & ~$past(pend_q)) == '0));

  p_pass_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= CNT_W'(LANES + 2));

endmodule

bind bank_scratch bank_scratch_chk #(.LANES(LANES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .pend_q     (pend_q)
);

// File: tb/bank_scratch_tb_top.sv
`timescale 1ns/1ps
module bank_scratch_tb_top;
  localparam int LANES  = 16;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int WORDS  = 1 << ADDR_W;

  // vector: {stride[4:0], base[9:0], expected passes[4:0]}
  localparam int NVEC = 11;
  localparam logic [19:0] VEC [NVEC] = '{
    {5'd1,  10'd0,   5'd1},   // R3 linear
    {5'd1,  10'd37,  5'd1},   // R3 linear, unaligned
    {5'd3,  10'd100, 5'd1},   // R3 odd stride permutation
    {5'd5,  10'd200, 5'd1},   // R3 odd stride permutation
    {5'd2,  10'd0,   5'd2},   // R4 2-way
    {5'd6,  10'd10,  5'd2},   // R4 2-way
    {5'd4,  10'd3,   5'd4},   // R4 4-way
    {5'd12, 10'd0,   5'd4},   // R4 4-way
    {5'd8,  10'd5,   5'd8},   // R4 8-way
    {5'd16, 10'd0,   5'd16},  // R4 16-way
    {5'd0,  10'd77,  5'd1}    // R5 broadcast
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    req_valid_i;
  logic                    req_ready_o;
  logic [LANES-1:0]        lane_act_i;
  logic [LANES-1:0]        lane_we_i;
  logic [LANES*ADDR_W-1:0] lane_addr_i;
  logic [LANES*DATA_W-1:0] lane_wdata_i;
  logic                    done_o;
  logic [LANES*DATA_W-1:0] rdata_o;

  always #2 clk = ~clk;

  bank_scratch dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .lane_act_i(lane_act_i), .lane_we_i(lane_we_i),
    .lane_addr_i(lane_addr_i), .lane_wdata_i(lane_wdata_i),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] model [WORDS];
  logic [ADDR_W-1:0] t_addr [LANES];
  logic [DATA_W-1:0] t_wd   [LANES];

  function automatic logic [DATA_W-1:0] fill(input int a);
    return 32'h5A5A_0000 + 32'(a) * 32'd3;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one request, measure passes, compare every lane's data
  task automatic issue(input logic [LANES-1:0] act, input logic [LANES-1:0] we,
                       input int exp_passes, input string req);
    logic [DATA_W-1:0] exp_rd [LANES];
    int passes;
    int bad;
    bit stall_ok;
    for (int l = 0; l < LANES; l++) begin
      exp_rd[l] = act[l] ? model[t_addr[l]] : rdata_o[l*DATA_W +: DATA_W];
    end
    while (!req_ready_o) @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      lane_addr_i[l*ADDR_W +: ADDR_W]  = t_addr[l];
      lane_wdata_i[l*DATA_W +: DATA_W] = t_wd[l];
    end
    lane_act_i  = act;
    lane_we_i   = we;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    passes   = 0;
    stall_ok = 1'b1;
    forever begin
      if (req_ready_o) stall_ok = 1'b0;
      @(posedge clk);
      passes++;
      @(negedge clk);
      if (done_o || passes > 40) break;
    end
    check(passes == exp_passes, req, passes, exp_passes);
    check(stall_ok && req_ready_o, "R6/R7 ready low while serializing", stall_ok, 1);
    @(posedge clk);
    @(negedge clk);
    check(!done_o, "R7 done one cycle", done_o, 0);
    bad = 0;
    for (int l = 0; l < LANES; l++) begin
      if (rdata_o[l*DATA_W +: DATA_W] !== exp_rd[l]) begin
        if (bad == 0) check(1'b0, {req, " data"}, rdata_o[l*DATA_W +: DATA_W], exp_rd[l]);
        bad++;
      end
    end
    if (bad == 0) check(1'b1, req, 0, 0);
    for (int l = 0; l < LANES; l++) begin
      if (act[l] && we[l]) model[t_addr[l]] = t_wd[l];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid_i = 1'b0;
    lane_act_i = '0;
    lane_we_i = '0;
    lane_addr_i = '0;
    lane_wdata_i = '0;
    for (int a = 0; a < WORDS; a++) model[a] = 'x;
    repeat (3) @(negedge clk);
    check(!req_ready_o && !done_o, "R11 reset outputs", {req_ready_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_ready_o, "R11 ready held after release", req_ready_o, 0);
    @(negedge clk);
    @(negedge clk);
    check(req_ready_o && !done_o, "R11 ready after sync", {req_ready_o, done_o}, 2'b10);

    // fill the whole store with linear writes (R1, R2, R3)
    for (int k = 0; k < WORDS / LANES; k++) begin
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = ADDR_W'(k * LANES + l);
        t_wd[l]   = fill(k * LANES + l);
      end
      issue('1, '1, 1, "R2 linear write one pass");
      for (int l = 0; l < LANES; l++) model[t_addr[l]] = t_wd[l];
    end

    // table walk: read patterns with known conflict degree (R1, R3, R4, R5)
    for (int v = 0; v < NVEC; v++) begin
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = ADDR_W'(int'(VEC[v][14:5]) + l * int'(VEC[v][19:15]));
        t_wd[l]   = '0;
      end
      issue('1, '0, int'(VEC[v][4:0]), "R1/R3/R4/R5 pattern read");
    end

    // R8: all lanes write one word, highest lane wins; R9: reads see old value
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = 10'd300;
      t_wd[l]   = 32'hC0DE_0000 + 32'(l);
    end
    issue('1, '1, 1, "R8/R9 same-address writes");
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = ADDR_W'(288 + l);
      t_wd[l]   = '0;
    end
    issue('1, '0, 1, "R8 highest lane stored");
    check(rdata_o[12*DATA_W +: DATA_W] == 32'hC0DE_000F, "R8 lane15 value",
          rdata_o[12*DATA_W +: DATA_W], 32'hC0DE_000F);

    // R9: lane 0 writes word 400, lane 1 reads it in the same pass
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = ADDR_W'(400 + 16 * l);
      t_wd[l]   = '0;
    end
    t_addr[1] = 10'd400;
    t_wd[0]   = 32'hBEEF_0001;
    issue(16'h0003, 16'h0001, 1, "R9 read before write");
    check(rdata_o[1*DATA_W +: DATA_W] == fill(400), "R9 old value",
          rdata_o[1*DATA_W +: DATA_W], fill(400));

    // R10: half the lanes idle, then no lane active
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = ADDR_W'(600 + l);
      t_wd[l]   = 32'hDEAD_0000;
    end
    issue(16'h00FF, 16'hFF00, 1, "R10 partial request");
    issue(16'h0000, 16'hFFFF, 1, "R10 empty request");
    issue('1, '0, 1, "R10 idle lanes wrote nothing");

    // R6: valid while stalled is ignored
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = ADDR_W'(16 * l);
      lane_addr_i[l*ADDR_W +: ADDR_W] = t_addr[l];
    end
    lane_act_i = '1;
    lane_we_i  = '0;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      lane_addr_i[l*ADDR_W +: ADDR_W]  = ADDR_W'(500 + l);
      lane_wdata_i[l*DATA_W +: DATA_W] = 32'hBAD0_0000;
    end
    lane_we_i = '1;
    repeat (5) begin
      check(!req_ready_o, "R6 ready low during stall", req_ready_o, 0);
      @(negedge clk);
    end
    req_valid_i = 1'b0;
    while (!done_o) @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = ADDR_W'(500 + l);
      t_wd[l]   = '0;
    end
    issue('1, '0, 1, "R6 stalled valid ignored");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule